// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-to-physical page translations that sits in front of a page walker. A lookup is answered in the same cycle it is presented. The answer gives hit or miss, the physical address, the write and execute rights of the page, and whether the access breaks those rights. On a miss the requester runs a page walk elsewhere and hands the result back through the fill port. The block keeps no memory traffic of its own.

Each entry maps either a 4 KiB page or a 2 MiB page. A 2 MiB entry answers for all 512 small pages inside its region. Software-driven consistency uses two ports. The invalidate port removes whichever entry translates a given virtual page number, so that stale rights are dropped. The flush port empties the whole buffer in one cycle. When a fill finds no free slot, the least recently used entry is replaced.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss.
- R2: After a 4 KiB fill of virtual page number V with frame number P, a lookup of any address in page V hits in the same cycle it is presented. It returns the physical address {P, vaddr[11:0]}.
- R3: A fill with the huge flag set covers every page number whose bits [35:9] equal those of the filled number. Its physical address is {P[27:9], vaddr[20:0]}, and the low 9 bits of the filled page and frame numbers are ignored.
- R4: A lookup that matches no entry raises lk_miss and lowers lk_hit. When lk_valid is low, both lk_hit and lk_miss are low.
- R5: On a hit, lk_perm_w and lk_perm_x carry the stored rights. lk_fault rises when lk_write is set on an entry without write rights, or when lk_exec is set on an entry without execute rights.
- R6: An invalidate of page number V removes every entry that translates V: a 4 KiB entry equal to V, or a 2 MiB entry whose region contains V. From the next cycle such lookups miss, and other entries are kept.
- R7: A lookup in the same cycle as an invalidate that removes its entry reports a miss.
- R8: A flush empties every entry at the next clock edge. A fill presented in the same cycle as a flush is discarded.
- R9: A fill whose page number and page size match an existing entry overwrites that entry instead of adding a second one. Later lookups return the new frame number.
- R10: A fill uses a free entry when one exists and otherwise replaces the least recently used entry. Use is recorded by fills and by lookup hits in cycles without a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_exec | input | 1 | Lookup is for an instruction fetch |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation, walk needed |
| lk_paddr | output | 40 | Translated physical address (0 on miss) |
| lk_perm_w | output | 1 | Hit entry allows writes |
| lk_perm_x | output | 1 | Hit entry allows execution |
| lk_fault | output | 1 | Access breaks the hit entry's rights |
| fill_valid | input | 1 | Install a walk result |
| fill_vpn | input | 36 | Virtual page number of the fill |
| fill_ppn | input | 28 | Physical frame number of the fill |
| fill_huge | input | 1 | Fill maps a 2 MiB page |
| fill_w | input | 1 | Write right of the fill |
| fill_x | input | 1 | Execute right of the fill |
| inv_valid | input | 1 | Invalidate request |
| inv_vpn | input | 36 | Virtual page number to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
Lookup results are combinational, so they are due in the cycle the request is driven. The bench drives inputs just after the falling edge and samples one nanosecond later, well before the next rising edge. Fills, invalidates and flushes take effect at the following rising edge, so their effect is first checked on a lookup driven in the next cycle. The exception is the same-cycle masking of R7, which is checked in the cycle the invalidate is presented. The reference model updates its own entries and recency stamps only after that rising edge, so it always predicts from the state the design holds.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned DEF_VA_W      = 48;
  localparam int unsigned DEF_PA_W      = 40;
  localparam int unsigned DEF_ENTRIES   = 16;
  localparam int unsigned DEF_PG_SHIFT  = 12;
  localparam int unsigned DEF_HUGE_BITS = 9;

  // Where a fill lands
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_EVICT = 2'd2
  } slot_src_e;
endpackage

// File: rtl/xlat_match.sv
// Tag compare for one entry; a huge entry ignores the low HUGE_BITS of the key.
module xlat_match #(
  parameter int unsigned VPN_W     = 36,
  parameter int unsigned HUGE_BITS = 9
) (
  input  logic             e_valid,
  input  logic             e_huge,
  input  logic [VPN_W-1:0] e_tag,
  input  logic [VPN_W-1:0] key,
  output logic             hit
);
  logic hi_eq;
  logic lo_eq;

  always_comb begin
    hi_eq = (e_tag[VPN_W-1:HUGE_BITS] == key[VPN_W-1:HUGE_BITS]);
    lo_eq = (e_tag[HUGE_BITS-1:0] == key[HUGE_BITS-1:0]);
    hit   = e_valid & hi_eq & (e_huge | lo_eq);
  end
endmodule

// File: rtl/xlat_lru.sv
// Age-ordered recency: ages form a permutation, 0 is most recent.
module xlat_lru #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];
  logic [IDX_W-1:0] touch_age;

  always_comb begin
    touch_age = age_q[touch_idx];
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)
          age_d[i] = '0;
        else if (age_q[i] < touch_age)
          age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IDX_W'(ENTRIES - 1))
        victim_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++)
        age_q[i] <= age_d[i];
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W      = DEF_VA_W,
  parameter int unsigned PA_W      = DEF_PA_W,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned PG_SHIFT  = DEF_PG_SHIFT,
  parameter int unsigned HUGE_BITS = DEF_HUGE_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic                     lk_write,
  input  logic                     lk_exec,
  output logic                     lk_hit,
  output logic                     lk_miss,
  output logic [PA_W-1:0]          lk_paddr,
  output logic                     lk_perm_w,
  output logic                     lk_perm_x,
  output logic                     lk_fault,
  input  logic                     fill_valid,
  input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
  input  logic                     fill_huge,
  input  logic                     fill_w,
  input  logic                     fill_x,
  input  logic                     inv_valid,
  input  logic [VA_W-PG_SHIFT-1:0] inv_vpn,
  input  logic                     flush
);
  localparam int unsigned VPN_W    = VA_W - PG_SHIFT;
  localparam int unsigned PPN_W    = PA_W - PG_SHIFT;
  localparam int unsigned IDX_W    = $clog2(ENTRIES);
  localparam int unsigned HUGE_OFF = PG_SHIFT + HUGE_BITS;

  // Entry state
  logic [ENTRIES-1:0] v_q, v_d;
  logic [ENTRIES-1:0] huge_q, w_q, x_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  // Match vectors
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_m, inv_m, fill_m, dup_m, eff_m, we;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_SHIFT];

  genvar g;
  for (g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_match #(.VPN_W(VPN_W), .HUGE_BITS(HUGE_BITS)) u_lk (
      .e_valid(v_q[g]), .e_huge(huge_q[g]), .e_tag(tag_q[g]),
      .key(lk_vpn), .hit(lk_m[g]));
    xlat_match #(.VPN_W(VPN_W), .HUGE_BITS(HUGE_BITS)) u_inv (
      .e_valid(v_q[g]), .e_huge(huge_q[g]), .e_tag(tag_q[g]),
      .key(inv_vpn), .hit(inv_m[g]));
    xlat_match #(.VPN_W(VPN_W), .HUGE_BITS(HUGE_BITS)) u_fill (
      .e_valid(v_q[g]), .e_huge(huge_q[g]), .e_tag(tag_q[g]),
      .key(fill_vpn), .hit(fill_m[g]));
    assign dup_m[g] = fill_m[g] & (huge_q[g] == fill_huge);
  end

  // Lookup: an invalidate in flight hides the entries it removes
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [PPN_W-1:0] ppn_sel;
  logic             huge_sel;

  always_comb begin
    eff_m   = lk_m & ~(inv_valid ? inv_m : '0);
    any_hit = |eff_m;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (eff_m[i]) hit_idx = IDX_W'(i);
    ppn_sel  = ppn_q[hit_idx];
    huge_sel = huge_q[hit_idx];
  end

  always_comb begin
    lk_hit    = lk_valid & any_hit;
    lk_miss   = lk_valid & ~any_hit;
    lk_perm_w = lk_hit & w_q[hit_idx];
    lk_perm_x = lk_hit & x_q[hit_idx];
    lk_fault  = lk_hit & ((lk_write & ~w_q[hit_idx]) | (lk_exec & ~x_q[hit_idx]));
    if (!lk_hit)
      lk_paddr = '0;
    else if (huge_sel)
      lk_paddr = {ppn_sel[PPN_W-1:HUGE_BITS], lk_vaddr[HUGE_OFF-1:0]};
    else
      lk_paddr = {ppn_sel, lk_vaddr[PG_SHIFT-1:0]};
  end

  // Fill slot choice: same page first, then a free slot, then the LRU victim
  logic [IDX_W-1:0] dup_idx, free_idx, victim_idx, fill_slot;
  slot_src_e        fill_src;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_m[i]) dup_idx  = IDX_W'(i);
      if (!v_q[i])  free_idx = IDX_W'(i);
    end
    if (|dup_m)
      fill_src = SLOT_REUSE;
    else if (!(&v_q))
      fill_src = SLOT_FREE;
    else
      fill_src = SLOT_EVICT;
    case (fill_src)
      SLOT_REUSE: fill_slot = dup_idx;
      SLOT_FREE:  fill_slot = free_idx;
      default:    fill_slot = victim_idx;
    endcase
  end

  // Recency
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;

  always_comb begin
    touch_en  = ~flush & (fill_valid | lk_hit);
    touch_idx = fill_valid ? fill_slot : hit_idx;
  end

  xlat_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .victim_idx(victim_idx));

  // Next state of valid bits
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      we[i] = fill_valid & ~flush & (fill_slot == IDX_W'(i));
    if (flush)
      v_d = '0;
    else
      v_d = (v_q & ~(inv_valid ? inv_m : '0)) | we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      v_q <= '0;
    else
      v_q <= v_d;
  end

  // Payload, written only under its enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we[i]) begin
        tag_q[i]  <= fill_vpn;
        ppn_q[i]  <= fill_ppn;
        huge_q[i] <= fill_huge;
        w_q[i]    <= fill_w;
        x_q[i]    <= fill_x;
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VPN_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_write,
  input logic             lk_exec,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             fill_huge,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             flush
);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && (lk_write || lk_exec)));

  p_same_cycle_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && lk_valid && lk_vpn == inv_vpn) |-> !lk_hit);

  p_inv_removes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(inv_valid && !fill_valid) && lk_vpn == $past(inv_vpn)) |-> !lk_hit);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_valid && !fill_huge && !flush && !inv_valid)
     && lk_vpn == $past(fill_vpn) && !(inv_valid && inv_vpn == lk_vpn)) |-> lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VA_W - PG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
  .lk_vpn(lk_vaddr[VA_W-1:PG_SHIFT]), .lk_write(lk_write), .lk_exec(lk_exec),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_huge(fill_huge),
  .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush));

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int N = 16;

  logic        clk, rst_n;
  logic        lk_valid, lk_write, lk_exec;
  logic [47:0] lk_vaddr;
  logic        lk_hit, lk_miss, lk_perm_w, lk_perm_x, lk_fault;
  logic [39:0] lk_paddr;
  logic        fill_valid, fill_huge, fill_w, fill_x;
  logic [35:0] fill_vpn;
  logic [27:0] fill_ppn;
  logic        inv_valid, flush;
  logic [35:0] inv_vpn;

  xlat_cache u_xlat_cache (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // Reference model
  bit          m_v [N];
  logic [35:0] m_vpn [N];
  logic [27:0] m_ppn [N];
  bit          m_huge [N], m_w [N], m_x [N];
  int          m_stamp [N];
  int          now = 0;

  logic [39:0] s_paddr;
  logic        s_hit;

  function automatic bit covers(int i, logic [35:0] vpn);
    return m_v[i] && (m_huge[i] ? (m_vpn[i][35:9] == vpn[35:9]) : (m_vpn[i] == vpn));
  endfunction

  function automatic int m_find(logic [35:0] vpn);
    for (int i = 0; i < N; i++) if (covers(i, vpn)) return i;
    return -1;
  endfunction

  function automatic logic [35:0] pool(int k);
    return 36'(64'h0_00A5_0000 + k * 3 + (k / 5) * 1024);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_exec = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_huge = 0; fill_w = 0; fill_x = 0;
    inv_valid = 0; inv_vpn = '0; flush = 0;
  endtask

  // One cycle: check combinational lookup, then update the model at the edge
  task automatic tick();
    int hidx;
    logic [35:0] vpn;
    logic [39:0] ep;
    bit eh, ef;
    #1;
    vpn  = lk_vaddr[47:12];
    hidx = lk_valid ? m_find(vpn) : -1;
    if (hidx >= 0 && inv_valid && covers(hidx, inv_vpn)) hidx = -1;
    eh = (hidx >= 0);
    s_hit = lk_hit; s_paddr = lk_paddr;
    if (!lk_valid) begin
      chk(!lk_hit && !lk_miss, "R4", "idle hit/miss", {lk_hit, lk_miss}, 0);
    end else begin
      chk(lk_hit == eh && lk_miss == !eh, cur_req, "hit/miss", {lk_hit, lk_miss}, {eh, !eh});
      if (eh) begin
        ep = m_huge[hidx] ? {m_ppn[hidx][27:9], lk_vaddr[20:0]} : {m_ppn[hidx], lk_vaddr[11:0]};
        ef = (lk_write && !m_w[hidx]) || (lk_exec && !m_x[hidx]);
        chk(lk_paddr == ep, cur_req, "paddr", lk_paddr, ep);
        chk(lk_perm_w == m_w[hidx] && lk_perm_x == m_x[hidx] && lk_fault == ef, cur_req,
            "perm/fault", {lk_perm_w, lk_perm_x, lk_fault}, {m_w[hidx], m_x[hidx], ef});
      end
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (eh && !fill_valid) m_stamp[hidx] = now;
      if (inv_valid)
        for (int i = 0; i < N; i++) if (covers(i, inv_vpn)) m_v[i] = 0;
      if (fill_valid) begin
        int s = -1;
        for (int i = 0; i < N; i++)
          if (s < 0 && m_v[i] && m_huge[i] == fill_huge && covers(i, fill_vpn)) s = i;
        for (int i = 0; i < N; i++) if (s < 0 && !m_v[i]) s = i;
        if (s < 0) begin
          s = 0;
          for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[s]) s = i;
        end
        m_v[s] = 1; m_vpn[s] = fill_vpn; m_ppn[s] = fill_ppn;
        m_huge[s] = fill_huge; m_w[s] = fill_w; m_x[s] = fill_x; m_stamp[s] = now;
      end
    end
    now++;
    @(negedge clk);
    idle();
  endtask

  task automatic do_fill(logic [35:0] vpn, logic [27:0] ppn, bit huge, bit w, bit x);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_huge = huge; fill_w = w; fill_x = x;
    tick();
  endtask

  task automatic do_look(logic [35:0] vpn, logic [11:0] off, bit wr, bit ex);
    lk_valid = 1; lk_vaddr = {vpn, off}; lk_write = wr; lk_exec = ex;
    tick();
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] hv;
    logic [27:0] hp;
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    cur_req = "R1";
    do_look(pool(0), 12'h000, 0, 0);
    chk(!s_hit, "R1", "reset lookup", s_hit, 0);

    // R2: small page translation
    cur_req = "R2";
    do_fill(pool(1), 28'h1234567, 0, 1, 0);
    do_look(pool(1), 12'hABC, 0, 0);
    chk(s_paddr == 40'h1234567ABC, "R2", "small paddr", s_paddr, 40'h1234567ABC);

    // R4: miss and idle
    cur_req = "R4";
    do_look(pool(9), 12'h010, 0, 0);
    tick();

    // R5: rights and faults
    cur_req = "R5";
    do_fill(pool(2), 28'h0000777, 0, 0, 1);
    do_look(pool(1), 12'h004, 1, 0);
    do_look(pool(2), 12'h008, 1, 0);
    do_look(pool(1), 12'h00C, 0, 1);
    do_look(pool(2), 12'h00C, 0, 1);

    // R3: huge page
    cur_req = "R3";
    hv = 36'h0_0040_0000;
    hp = 28'h0ABC1FF;
    do_fill(hv | 36'h0AA, hp, 1, 1, 1);
    do_look(hv | 36'h1A5, 12'h321, 0, 0);
    chk(s_paddr == {hp[27:9], 9'h1A5, 12'h321}, "R3", "huge paddr", s_paddr,
        {hp[27:9], 9'h1A5, 12'h321});
    do_look(hv + 36'd512, 12'h000, 0, 0);
    chk(!s_hit, "R3", "outside region", s_hit, 0);

    // R6: invalidate inside huge region
    cur_req = "R6";
    inv_valid = 1; inv_vpn = hv | 36'h055;
    tick();
    do_look(hv, 12'h000, 0, 0);
    chk(!s_hit, "R6", "huge removed", s_hit, 0);
    do_look(pool(1), 12'h000, 0, 0);
    chk(s_hit, "R6", "other kept", s_hit, 1);

    // R7: same-cycle invalidate masks lookup
    cur_req = "R7";
    inv_valid = 1; inv_vpn = pool(1);
    lk_valid = 1; lk_vaddr = {pool(1), 12'h000};
    tick();
    chk(!s_hit, "R7", "masked lookup", s_hit, 0);
    do_look(pool(1), 12'h000, 0, 0);
    do_look(pool(2), 12'h000, 0, 0);

    // R9: refill of a present page overwrites
    cur_req = "R9";
    do_fill(pool(3), 28'h0000AAA, 0, 1, 1);
    do_fill(pool(3), 28'h0000BBB, 0, 1, 1);
    do_look(pool(3), 12'h000, 0, 0);
    chk(s_paddr == 40'h0000BBB000, "R9", "overwrite ppn", s_paddr, 40'h0000BBB000);

    // R8: flush, and flush beats fill
    cur_req = "R8";
    do_flush();
    do_look(pool(2), 12'h000, 0, 0);
    chk(!s_hit, "R8", "after flush", s_hit, 0);
    flush = 1; fill_valid = 1; fill_vpn = pool(4); fill_ppn = 28'h1; fill_w = 1;
    tick();
    do_look(pool(4), 12'h000, 0, 0);
    chk(!s_hit, "R8", "fill dropped", s_hit, 0);

    // R10: LRU replacement
    cur_req = "R10";
    do_flush();
    for (int k = 30; k < 46; k++) do_fill(pool(k), 28'(k), 0, 1, 1);
    do_look(pool(30), 12'h000, 0, 0);
    do_fill(pool(46), 28'd46, 0, 1, 1);
    do_look(pool(31), 12'h000, 0, 0);
    chk(!s_hit, "R10", "lru evicted", s_hit, 0);
    do_look(pool(30), 12'h000, 0, 0);
    chk(s_hit, "R10", "touched kept", s_hit, 1);
    do_look(pool(46), 12'h000, 0, 0);

    // Random mix, small pages only
    cur_req = "R10";
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 100;
      if (($urandom % 10) < 7) begin
        lk_valid = 1;
        lk_vaddr = {pool($urandom % 24), 12'($urandom)};
        lk_write = $urandom % 2; lk_exec = $urandom % 2;
      end
      if (r < 25) begin
        fill_valid = 1; fill_vpn = pool($urandom % 24); fill_ppn = 28'($urandom);
        fill_w = $urandom % 2; fill_x = $urandom % 2;
      end else if (r < 30) begin
        inv_valid = 1; inv_vpn = pool($urandom % 24);
      end else if (r == 99) begin
        flush = 1;
      end
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule